// File: doc/BRIEF.md
# Variable-Length Instruction Field Decoder

This block splits one instruction of a small 32-bit register-machine instruction set into its fields. It sees the program counter and a six-byte window of instruction memory that starts at that address. From the first byte alone it works out which of four layouts the instruction uses: 1, 2, 5 or 6 bytes. It then returns the operation and variant nibbles, the two register selectors, the 32-bit constant and the length. It also gives the address of the next sequential instruction and a flag for an illegal encoding.

The decoder is purely combinational and holds no state. The surrounding fetch logic supplies the window and uses the length and next address to step through the program. The execute stage consumes the fields. Register selectors are 4 bits wide: values 0 to 7 name the eight general registers, and 0xF means "no register". Constants are stored least-significant byte first.

Top module: `instr_field_decoder`

## Requirements
- R1: `window_i[8k+7:8k]` holds the byte at address PC+k (k = 0..5). `icode_o` always equals bits [7:4] of byte 0 and `ifun_o` always equals bits [3:0] of byte 0, whether or not the encoding is legal.
- R2: `invalid_o` is 1 in three cases: the operation nibble is above 0xB; the operation is 0x2 or 0x7 with a variant above 6; the operation is 0x6 with a variant above 3. For every other operation nibble (0, 1, 3, 4, 5, 8, 9, 0xA, 0xB), `invalid_o` is 1 when the variant is not 0. It is 0 otherwise.
- R3: For a legal encoding, `len_o` follows the operation nibble: 1 for 0x0, 0x1 and 0x9; 2 for 0x2, 0x6, 0xA and 0xB; 5 for 0x7 and 0x8; 6 for 0x3, 0x4 and 0x5. When `invalid_o` is 1, `len_o` is 1.
- R4: For a legal 2-byte or 6-byte instruction, `ra_o` is bits [7:4] of byte 1 and `rb_o` is bits [3:0] of byte 1, passed through unchanged (including any 0xF present in the encoding).
- R5: For a legal 1-byte or 5-byte instruction, and for any illegal encoding, `ra_o` and `rb_o` are both 0xF.
- R6: For a legal 6-byte instruction, `valc_o` is bytes 2..5 taken least-significant first: {byte5, byte4, byte3, byte2}. For example, 30 F2 cd ab 00 00 gives `valc_o`=0x0000abcd, `ra_o`=0xF and `rb_o`=2.
- R7: For a legal 5-byte instruction, `valc_o` is {byte4, byte3, byte2, byte1}.
- R8: For a legal 1-byte or 2-byte instruction, and for any illegal encoding, `valc_o` is 0.
- R9: `next_pc_o` equals `pc_i + len_o` modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of byte 0 of the window |
| window_i | input | 48 | Six fetched bytes, byte k at bits [8k+7:8k] |
| icode_o | output | 4 | Operation nibble |
| ifun_o | output | 4 | Variant nibble |
| ra_o | output | 4 | First register selector, 0xF if absent |
| rb_o | output | 4 | Second register selector, 0xF if absent |
| valc_o | output | 32 | Decoded constant, 0 if absent |
| len_o | output | 3 | Instruction length in bytes |
| next_pc_o | output | 32 | Address of the following instruction |
| invalid_o | output | 1 | Illegal encoding |

## Verification
The bench sweeps all 256 values of the first byte, fills the other five bytes with fresh values each time, and checks every output against a model derived from the requirements.

- Variant limits: a decoder with an off-by-one limit would accept 0x27, 0x64 or 0x77, or reject 0x26, 0x63 or 0x76. The sweep catches either error at the boundary.
- Constant byte order and alignment: a decoder that took the wrong starting byte, or assembled the bytes in the wrong order, would return a shifted or byte-reversed constant. The worked examples and the random filler expose this.
- Illegal encodings: a decoder that leaked register or constant fields through on an illegal byte would show stray values where 0xF and 0 are expected.
- Address wrap: a program counter just below 2^32 checks that the next address wraps rather than saturating.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned WIN_BYTES  = WORD_BYTES + 2;
  localparam int unsigned WIN_W      = 8 * WIN_BYTES;
  localparam int unsigned WORD_W     = 8 * WORD_BYTES;
  localparam int unsigned LEN_W      = $clog2(WIN_BYTES + 1);

  localparam logic [NIB_W-1:0] REG_NONE = '1;

  typedef enum logic [NIB_W-1:0] {
    OP_STOP     = 4'h0,
    OP_IDLE     = 4'h1,
    OP_MOVE_RR  = 4'h2,
    OP_LOAD_IMM = 4'h3,
    OP_STORE    = 4'h4,
    OP_LOAD     = 4'h5,
    OP_ALU      = 4'h6,
    OP_BRANCH   = 4'h7,
    OP_CALL     = 4'h8,
    OP_RET      = 4'h9,
    OP_PUSH     = 4'hA,
    OP_POP      = 4'hB
  } op_e;

  // layout class: which of register byte / constant word follow the opcode
  typedef enum logic [1:0] {
    FMT_BARE      = 2'd0,
    FMT_REGS      = 2'd1,
    FMT_WORD      = 2'd2,
    FMT_REGS_WORD = 2'd3
  } fmt_e;

  function automatic logic [LEN_W-1:0] fmt_len(input fmt_e f);
    case (f)
      FMT_REGS:      fmt_len = LEN_W'(2);
      FMT_WORD:      fmt_len = LEN_W'(1 + WORD_BYTES);
      FMT_REGS_WORD: fmt_len = LEN_W'(2 + WORD_BYTES);
      default:       fmt_len = LEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ifd_classify.sv
module ifd_classify
  import ifd_pkg::*;
(
  input  logic [7:0]       op_byte_i,
  output fmt_e             fmt_o,
  output logic [LEN_W-1:0] len_o,
  output logic             invalid_o
);
  logic [NIB_W-1:0] icode, ifun, max_fun;
  logic             known;
  fmt_e             fmt_raw;

  assign icode = op_byte_i[7:4];
  assign ifun  = op_byte_i[3:0];

  always_comb begin
    known   = 1'b1;
    max_fun = '0;
    fmt_raw = FMT_BARE;
    case (icode)
      OP_STOP, OP_IDLE, OP_RET:       fmt_raw = FMT_BARE;
      OP_MOVE_RR: begin max_fun = 4'd6; fmt_raw = FMT_REGS; end
      OP_ALU:     begin max_fun = 4'd3; fmt_raw = FMT_REGS; end
      OP_PUSH, OP_POP:                fmt_raw = FMT_REGS;
      OP_BRANCH:  begin max_fun = 4'd6; fmt_raw = FMT_WORD; end
      OP_CALL:                        fmt_raw = FMT_WORD;
      OP_LOAD_IMM, OP_STORE, OP_LOAD: fmt_raw = FMT_REGS_WORD;
      default:                        known   = 1'b0;
    endcase
  end

  assign invalid_o = !known || (ifun > max_fun);
  // illegal encodings collapse to the bare layout: length 1, no fields
  assign fmt_o     = invalid_o ? FMT_BARE : fmt_raw;
  assign len_o     = fmt_len(fmt_o);

  always_comb begin
    // R2
    high_op_chk: assert (!(op_byte_i[7:4] > 4'hB) || invalid_o)
      else $error("opcode above 0xB accepted");
    // R3
    len_legal_chk: assert (len_o == 1 || len_o == 2 || len_o == 5 || len_o == 6)
      else $error("illegal length %0d", len_o);
  end
endmodule

// File: rtl/ifd_field_extract.sv
module ifd_field_extract
  import ifd_pkg::*;
(
  input  logic [WIN_W-1:0]  window_i,
  input  fmt_e              fmt_i,
  output logic [NIB_W-1:0]  ra_o,
  output logic [NIB_W-1:0]  rb_o,
  output logic [WORD_W-1:0] valc_o
);
  logic [WORD_W-1:0] word_after_regs, word_after_op;

  // two fixed alignments; byte order already little-endian in the window
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_word
    assign word_after_regs[8*k +: 8] = window_i[8*(k+2) +: 8];
    assign word_after_op[8*k +: 8]   = window_i[8*(k+1) +: 8];
  end

  logic has_regs;
  assign has_regs = (fmt_i == FMT_REGS) || (fmt_i == FMT_REGS_WORD);

  assign ra_o = has_regs ? window_i[15:12] : REG_NONE;
  assign rb_o = has_regs ? window_i[11:8]  : REG_NONE;

  always_comb begin
    case (fmt_i)
      FMT_REGS_WORD: valc_o = word_after_regs;
      FMT_WORD:      valc_o = word_after_op;
      default:       valc_o = '0;
    endcase
  end

  always_comb begin
    // R6
    word_regs_chk: assert (fmt_i != FMT_REGS_WORD || valc_o[7:0] == window_i[23:16])
      else $error("constant low byte misaligned");
    // R7
    word_op_chk: assert (fmt_i != FMT_WORD || valc_o[WORD_W-1 -: 8] == window_i[39:32])
      else $error("constant high byte misaligned");
  end
endmodule

// File: rtl/ifd_next_pc.sv
module ifd_next_pc #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  assign next_pc_o = pc_i + ADDR_W'(len_i);
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
  import ifd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [WIN_W-1:0]  window_i,
  output logic [NIB_W-1:0]  icode_o,
  output logic [NIB_W-1:0]  ifun_o,
  output logic [NIB_W-1:0]  ra_o,
  output logic [NIB_W-1:0]  rb_o,
  output logic [WORD_W-1:0] valc_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              invalid_o
);
  fmt_e fmt;

  assign icode_o = window_i[7:4];
  assign ifun_o  = window_i[3:0];

  ifd_classify u_classify (
    .op_byte_i (window_i[7:0]),
    .fmt_o     (fmt),
    .len_o     (len_o),
    .invalid_o (invalid_o)
  );

  ifd_field_extract u_extract (
    .window_i (window_i),
    .fmt_i    (fmt),
    .ra_o     (ra_o),
    .rb_o     (rb_o),
    .valc_o   (valc_o)
  );

  ifd_next_pc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_next_pc (
    .pc_i      (pc_i),
    .len_i     (len_o),
    .next_pc_o (next_pc_o)
  );

  always_comb begin
    // R9
    next_pc_step_chk: assert (next_pc_o - pc_i == ADDR_W'(len_o))
      else $error("next address not pc+len");
    // R3
    invalid_len_chk: assert (!invalid_o || len_o == 1)
      else $error("illegal encoding with length %0d", len_o);
    // R5
    reg_none_chk: assert (!(len_o == 1 || len_o == 5) || (ra_o == REG_NONE && rb_o == REG_NONE))
      else $error("register field on layout without register byte");
    // R8
    valc_zero_chk: assert (!(len_o == 1 || len_o == 2) || valc_o == '0)
      else $error("constant on layout without constant");
  end
endmodule

// File: tb/instr_field_decoder_test.sv
`timescale 1ns/1ps
module instr_field_decoder_test;
  logic        clk = 1'b0;
  logic [31:0] pc;
  logic [47:0] win;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, next_pc;
  logic [2:0]  len;
  logic        invalid;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  instr_field_decoder uut (
    .pc_i (pc), .window_i (win),
    .icode_o (icode), .ifun_o (ifun), .ra_o (ra), .rb_o (rb),
    .valc_o (valc), .len_o (len), .next_pc_o (next_pc), .invalid_o (invalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s win=%h pc=%h actual=%h expected=%h", req, win, pc, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] p, input logic [47:0] w);
    logic [3:0]  ic, fn, e_ra, e_rb;
    logic        ok;
    int          e_len;
    logic [31:0] e_valc;
    @(posedge clk);
    pc  = p;
    win = w;
    ic = w[7:4];
    fn = w[3:0];
    case (ic)
      4'h2, 4'h7: ok = (fn <= 4'd6);
      4'h6:       ok = (fn <= 4'd3);
      4'hC, 4'hD, 4'hE, 4'hF: ok = 1'b0;
      default:    ok = (fn == 4'd0);
    endcase
    if (!ok) e_len = 1;
    else case (ic)
      4'h2, 4'h6, 4'hA, 4'hB: e_len = 2;
      4'h7, 4'h8:             e_len = 5;
      4'h3, 4'h4, 4'h5:       e_len = 6;
      default:                e_len = 1;
    endcase
    if (ok && (e_len == 2 || e_len == 6)) begin e_ra = w[15:12]; e_rb = w[11:8]; end
    else begin e_ra = 4'hF; e_rb = 4'hF; end
    if (ok && e_len == 6)      e_valc = w[47:16];
    else if (ok && e_len == 5) e_valc = w[39:8];
    else                       e_valc = 32'h0;
    @(negedge clk);
    chk("R1 icode", 32'(icode), 32'(ic));
    chk("R1 ifun", 32'(ifun), 32'(fn));
    chk("R2 invalid", 32'(invalid), 32'(!ok));
    chk("R3 len", 32'(len), 32'(e_len));
    chk((e_len == 2 || e_len == 6) ? "R4 ra" : "R5 ra", 32'(ra), 32'(e_ra));
    chk((e_len == 2 || e_len == 6) ? "R4 rb" : "R5 rb", 32'(rb), 32'(e_rb));
    chk(e_len == 6 ? "R6 valc" : (e_len == 5 ? "R7 valc" : "R8 valc"), valc, e_valc);
    chk("R9 next_pc", next_pc, p + 32'(e_len));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    pc  = '0;
    win = '0;
    // reset-like idle state: all-zero window is a one-byte stop instruction
    @(negedge clk);
    chk("R3 idle len", 32'(len), 32'd1);
    chk("R5 idle ra", 32'(ra), 32'hF);
    chk("R9 idle next_pc", next_pc, 32'd1);
    // R6 worked examples, bytes listed from address PC upward
    run_case(32'h100, 48'h0000_abcd_f2_30);
    chk("R6 example imm", valc, 32'h0000abcd);
    chk("R6 example rb", 32'(rb), 32'h2);
    run_case(32'h200, 48'hffff_fff4_15_50);
    chk("R6 example neg disp", valc, 32'hfffffff4);
    run_case(32'h300, 48'h0001_2345_42_40);
    chk("R6 example disp", valc, 32'h00012345);
    // R7 five-byte destination
    run_case(32'h400, 48'hee_1234_5678_73);
    chk("R7 branch dest", valc, 32'h12345678);
    // R9 wrap around top of address space
    run_case(32'hffff_fffe, 48'h0000_abcd_f2_30);
    chk("R9 wrap", next_pc, 32'h4);
    run_case(32'hffff_ffff, 48'h0000_0000_00_80);
    chk("R9 wrap call", next_pc, 32'h4);
    // exhaustive sweep of the first byte with fresh filler
    for (int b = 0; b < 256; b++) begin
      for (int rep = 0; rep < 2; rep++) begin
        logic [47:0] w;
        w = {$urandom(), $urandom()} ;
        w[7:0] = 8'(b);
        run_case($urandom(), w);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule